// File: doc/BRIEF.md
# Dual-Port I2C Line Steering Unit

This block sits between one internal I2C protocol controller and two physical open-drain I2C bus ports. Each port has its own clock line and data line. The controller does not drive the bus directly. It raises a pull-down request for its clock line and another for its data line. The block turns each request into a drive-low enable on the matching line of every port whose enable bit is set. No line is ever driven high. Every port index is a bit position in the port vectors: bit 0 is port 0 and bit 1 is port 1.

In the receive direction, each external line passes through a two-flop synchroniser. The synchronised lines of the enabled ports are then combined as a wired-AND, so the controller sees a line low if any enabled port holds it low. Ports that are disabled are masked out. With no port enabled, both received lines read idle high. The drive path takes only the controller's requests and the enable bits, so activity on one external bus never reaches the other.

The enable bits are control inputs. They are registered, so a change takes effect after the next rising clock edge. The block has no data stream and no handshake. All pins are plain level signals.

Top module: `i2c_port_steer`

## Requirements
- R1: While reset is asserted and right after it is released, all drive-low enables are 0, both received lines read 1, and both ports count as disabled.
- R2: When port i is enabled, `bus_scl_oe[i]` equals `ctl_scl_pull` and `bus_sda_oe[i]` equals `ctl_sda_pull`. With both ports enabled, the request appears on both ports.
- R3: A drive-low enable of a disabled port is always 0, whatever the controller requests.
- R4: Line activity on a disabled port has no effect on `ctl_scl_rx` or `ctl_sda_rx`. With both ports disabled, both received lines read 1.
- R5: Each received line is the AND of the synchronised levels of that line on all enabled ports. A level sampled at one rising edge reaches the output after the following rising edge.
- R6: Line levels arriving on either port never change any drive-low enable, even with both ports enabled.
- R7: A change on `port_en` has no effect before the next rising clock edge and takes effect right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 2 | Port enable bits, bit i enables port i |
| ctl_scl_pull | input | 1 | Controller request to pull the clock line low |
| ctl_sda_pull | input | 1 | Controller request to pull the data line low |
| ctl_scl_rx | output | 1 | Received clock level from the combined enabled ports |
| ctl_sda_rx | output | 1 | Received data level from the combined enabled ports |
| bus_scl_in | input | 2 | Sensed clock line level of each port |
| bus_sda_in | input | 2 | Sensed data line level of each port |
| bus_scl_oe | output | 2 | Drive-low enable of each port's clock line |
| bus_sda_oe | output | 2 | Drive-low enable of each port's data line |

## Verification
The bench drives each enable setting: none, port 0 only, port 1 only, and both. Under each one it varies the controller requests and the line levels on both ports. With one port enabled, the bench shows that only that port's lines reach the controller and only that port is driven. With both enabled, it shows the wired-AND result and that both ports are driven. With pad activity and no controller request, every drive-low enable must stay 0, which shows that nothing is bridged between the buses. A directed step on the enable bits, sampled just before and just after the clock edge, checks the one-cycle latency. Every cycle is also compared with a behavioural reference model, which keeps a history queue of the sampled line levels.

// File: rtl/i2c_steer_pkg.sv
package i2c_steer_pkg;
  localparam int unsigned STEER_PORTS = 2;
  localparam int unsigned SYNC_DEPTH  = 2;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;
endpackage

// File: rtl/steer_sync.sv
module steer_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s] <= '1;
      end else if (s == 0) begin
        chain[s] <= d;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/steer_rx_merge.sv
module steer_rx_merge #(
  parameter int unsigned NPORT = 2
) (
  input  logic [NPORT-1:0] line_q,
  input  logic [NPORT-1:0] en_q,
  output logic             merged
);
  logic [NPORT-1:0] masked;

  for (genvar i = 0; i < NPORT; i++) begin : g_mask
    assign masked[i] = line_q[i] | ~en_q[i];
  end

  assign merged = &masked;
endmodule

// File: rtl/steer_tx_fanout.sv
module steer_tx_fanout #(
  parameter int unsigned NPORT = 2
) (
  input  logic             pull_req,
  input  logic [NPORT-1:0] en_q,
  output logic [NPORT-1:0] drive_low
);
  for (genvar i = 0; i < NPORT; i++) begin : g_fan
    assign drive_low[i] = pull_req & en_q[i];
  end
endmodule

// File: rtl/i2c_port_steer.sv
module i2c_port_steer
  import i2c_steer_pkg::*;
#(
  parameter int unsigned NPORT = STEER_PORTS,
  parameter int unsigned SYNC  = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_en,
  input  logic             ctl_scl_pull,
  input  logic             ctl_sda_pull,
  output logic             ctl_scl_rx,
  output logic             ctl_sda_rx,
  input  logic [NPORT-1:0] bus_scl_in,
  input  logic [NPORT-1:0] bus_sda_in,
  output logic [NPORT-1:0] bus_scl_oe,
  output logic [NPORT-1:0] bus_sda_oe
);
  localparam int unsigned LINES = 2 * NPORT;

  logic [NPORT-1:0] en_q;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  line_pair_t       pull_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= port_en;
  end

  assign raw_lines = {bus_sda_in, bus_scl_in};
  assign pull_req  = '{scl: ctl_scl_pull, sda: ctl_sda_pull};

  steer_sync #(.WIDTH(LINES), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lines),
    .q     (sync_lines)
  );

  steer_rx_merge #(.NPORT(NPORT)) u_merge_scl (
    .line_q (sync_lines[NPORT-1:0]),
    .en_q   (en_q),
    .merged (ctl_scl_rx)
  );

  steer_rx_merge #(.NPORT(NPORT)) u_merge_sda (
    .line_q (sync_lines[LINES-1:NPORT]),
    .en_q   (en_q),
    .merged (ctl_sda_rx)
  );

  steer_tx_fanout #(.NPORT(NPORT)) u_fan_scl (
    .pull_req  (pull_req.scl),
    .en_q      (en_q),
    .drive_low (bus_scl_oe)
  );

  steer_tx_fanout #(.NPORT(NPORT)) u_fan_sda (
    .pull_req  (pull_req.sda),
    .en_q      (en_q),
    .drive_low (bus_sda_oe)
  );
endmodule

// File: rtl/i2c_port_steer_chk.sv
module i2c_port_steer_chk #(
  parameter int unsigned NPORT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] port_en,
  input logic             ctl_scl_pull,
  input logic             ctl_sda_pull,
  input logic             ctl_scl_rx,
  input logic             ctl_sda_rx,
  input logic [NPORT-1:0] bus_scl_in,
  input logic [NPORT-1:0] bus_sda_in,
  input logic [NPORT-1:0] bus_scl_oe,
  input logic [NPORT-1:0] bus_sda_oe
);
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (bus_scl_oe == '0 && bus_sda_oe == '0);
    end
  end

  a_r4_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_en) == '0) |-> (ctl_scl_rx && ctl_sda_rx));

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    a_r3_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_scl_oe[i] || bus_sda_oe[i]) |-> $past(port_en[i]));

    a_r6_scl_oe_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_scl_oe[i] |-> ctl_scl_pull);

    a_r6_sda_oe_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sda_oe[i] |-> ctl_sda_pull);

    a_r2_scl_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(port_en[i]) && ctl_scl_pull) |-> bus_scl_oe[i]);

    a_r2_sda_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(port_en[i]) && ctl_sda_pull) |-> bus_sda_oe[i]);

    a_r5_scl_low_seen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(rst_n) && $past(port_en[i]) && !$past(bus_scl_in[i], 2))
      |-> !ctl_scl_rx);

    a_r5_sda_low_seen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(rst_n) && $past(port_en[i]) && !$past(bus_sda_in[i], 2))
      |-> !ctl_sda_rx);
  end
endmodule

bind i2c_port_steer i2c_port_steer_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/test_i2c_port_steer.sv
`timescale 1ns/1ps
module test_i2c_port_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] port_en = '0;
  logic       ctl_scl_pull = 1'b0, ctl_sda_pull = 1'b0;
  logic       ctl_scl_rx, ctl_sda_rx;
  logic [1:0] bus_scl_in = '1, bus_sda_in = '1;
  logic [1:0] bus_scl_oe, bus_sda_oe;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_port_steer i_i2c_port_steer (.*);

  // reference model state: enable seen at last edge, history of sampled pads
  logic [1:0] m_en = '0;
  logic [3:0] m_hist[$] = '{4'hF, 4'hF};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en   = '0;
      m_hist = '{4'hF, 4'hF};
    end else begin
      m_en = port_en;
      m_hist.push_back({bus_sda_in, bus_scl_in});
      void'(m_hist.pop_front());
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  task automatic compare_model();
    logic exp_scl, exp_sda;
    exp_scl = 1'b1;
    exp_sda = 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (m_en[i]) begin
        exp_scl &= m_hist[0][i];
        exp_sda &= m_hist[0][2+i];
      end
    end
    check(m_en == 0 ? "R4 scl rx" : "R5 scl rx", ctl_scl_rx, exp_scl);
    check(m_en == 0 ? "R4 sda rx" : "R5 sda rx", ctl_sda_rx, exp_sda);
    for (int i = 0; i < 2; i++) begin
      check(!m_en[i] ? "R3 scl oe" : (ctl_scl_pull ? "R2 scl oe" : "R6 scl oe"),
            bus_scl_oe[i], m_en[i] & ctl_scl_pull);
      check(!m_en[i] ? "R3 sda oe" : (ctl_sda_pull ? "R2 sda oe" : "R6 sda oe"),
            bus_sda_oe[i], m_en[i] & ctl_sda_pull);
    end
  endtask

  task automatic run_cycles(input logic [1:0] en, input int n, input bit pulls);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_model();
      port_en      = en;
      ctl_scl_pull = pulls ? 1'($urandom) : 1'b0;
      ctl_sda_pull = pulls ? 1'($urandom) : 1'b0;
      bus_scl_in   = 2'($urandom);
      bus_sda_in   = 2'($urandom);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bus_scl_in   = 2'b00;
    bus_sda_in   = 2'b00;
    ctl_scl_pull = 1'b1;
    ctl_sda_pull = 1'b1;
    port_en      = 2'b11;
    repeat (3) @(negedge clk);
    // R1: reset state held despite requests and enable inputs
    check("R1 scl oe", bus_scl_oe, 0);
    check("R1 sda oe", bus_sda_oe, 0);
    check("R1 scl rx", ctl_scl_rx, 1);
    check("R1 sda rx", ctl_sda_rx, 1);
    port_en = 2'b00;
    rst_n   = 1'b1;
    @(negedge clk);
    check("R1 oe after release", {bus_scl_oe, bus_sda_oe}, 0);

    // R4: pad activity with no port enabled
    run_cycles(2'b00, 40, 1'b1);
    // single ports, then both
    run_cycles(2'b01, 60, 1'b1);
    run_cycles(2'b10, 60, 1'b1);
    run_cycles(2'b11, 80, 1'b1);
    // R6: no requests, heavy pad activity on both enabled ports
    run_cycles(2'b11, 60, 1'b0);

    // R5: directed wired-AND, port 1 low only, both enabled
    @(negedge clk);
    compare_model();
    bus_scl_in = 2'b01;
    bus_sda_in = 2'b11;
    repeat (3) @(negedge clk);
    check("R5 wired and scl", ctl_scl_rx, 0);
    check("R5 wired and sda", ctl_sda_rx, 1);
    check("R6 no bridge", {bus_scl_oe, bus_sda_oe}, 0);

    // R7: enable step latency
    port_en      = 2'b00;
    ctl_scl_pull = 1'b1;
    ctl_sda_pull = 1'b0;
    @(negedge clk);
    check("R7 disabled after edge", bus_scl_oe, 0);
    port_en = 2'b10;
    #5;
    check("R7 before edge", bus_scl_oe, 0);
    @(negedge clk);
    check("R7 after edge", bus_scl_oe, 2'b10);
    check("R7 port1 rx now masked in", ctl_scl_rx, 0);

    run_cycles(2'b01, 20, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule